// File: doc/BRIEF.md
# Fixed-Point FIR Multiply-Accumulate Datapath

This block is the arithmetic core of an FIR filter section. Each cycle it can take one 16-bit two's complement sample and one 16-bit two's complement coefficient. Both are fractions with a single sign bit ahead of the binary point. The coefficient is first narrowed to 12 bits, rounding toward zero. The sample and the narrowed coefficient are then multiplied at the full 28-bit width. The four lowest bits of the product are dropped, and the remaining 24 bits are sign-extended into a 32-bit running sum. The sum has 10 integer bits and 22 fraction bits, which leaves 9 bits of headroom for word growth across the taps.

A sequencer outside this block steps through the taps. On the first tap of a new output it asserts `clear_load`, and on the later taps it asserts `acc_en`. The whole 32-bit sum is output. A 16-bit slice from the middle of the sum is also output, so it can feed the sample input of a second section when two sections are chained. The datapath has two register stages: a product stage, then the accumulator. `out_valid` marks each cycle in which the sum reflects a new accepted input.

The product stage registers an operation code with three states. `OP_HOLD` keeps the sum. `OP_LOAD` replaces the sum with the aligned product. `OP_ADD` adds the aligned product to the sum. The accumulator stage moves on each clock according to the registered code:
- `OP_HOLD` leaves the sum unchanged.
- `OP_LOAD` sets the sum to the aligned product.
- `OP_ADD` sets the sum to the old sum plus the aligned product.

Any code can follow any other code. The code is `OP_LOAD` when `in_valid` and `clear_load` are both high. It is `OP_ADD` when `in_valid` and `acc_en` are high and `clear_load` is low. In every other case it is `OP_HOLD`.

Top module: `fir_mac`

## Requirements
- R1: While `rst_n` is low, `acc_out`, `cascade_out` and `out_valid` are all zero.
- R2: The coefficient is narrowed to 12 bits by rounding toward zero, using its upper 12 bits. A non-negative value keeps those 12 bits as they are. A negative value with any of its low 4 bits set moves one step toward zero. For example, 0xFFFF becomes 0, 0xFFF0 becomes -1, and 0x8001 becomes -2047.
- R3: The product is exact for every operand pair. Sample 0x8000 times coefficient 0x8000 loads 0x00400000 into the sum.
- R4: The 4 dropped product bits are truncated toward minus infinity. Sample 0xFFFF times coefficient 0x0010 loads 0xFFFFFFFF, and sample 0x0001 times the same coefficient loads 0.
- R5: An input with `in_valid` and `clear_load` high replaces the sum with its aligned product. In that case `clear_load` takes priority over `acc_en`.
- R6: An input with `in_valid` and `acc_en` high and `clear_load` low adds its aligned product to the sum.
- R7: An input with `in_valid` low, or with both `clear_load` and `acc_en` low, leaves the sum unchanged.
- R8: The effect of an input shows on `acc_out` two rising clock edges after it is presented. `out_valid` is high in that same cycle exactly when `in_valid` was high.
- R9: The sum wraps modulo 2^32 and never saturates. One load followed by 511 adds of 0x00400000 gives 0x80000000.
- R10: `cascade_out` always equals bits 23 down to 8 of `acc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The sample and coefficient are valid this cycle |
| clear_load | input | 1 | Start a new sum with this product |
| acc_en | input | 1 | Add this product to the running sum |
| data_in | input | 16 | Signed Q1.15 sample |
| coef_in | input | 16 | Signed Q1.15 coefficient |
| acc_out | output | 32 | Signed Q10.22 running sum |
| cascade_out | output | 16 | Middle slice of the sum, bits 23 down to 8 |
| out_valid | output | 1 | `acc_out` reflects a newly accepted input |

## Verification
The state that is hardest to reach from the ports is the wrap at the top of the 9 guard bits. Only a long run of full-scale products can get there. The stimulus loads the most negative operand pair once, then repeats it as adds for 511 more cycles. This moves the sum through every guard bit until it crosses into the sign bit. The other corners are also covered with mixed streams checked against an independent integer model of the fixed-point arithmetic:
- rounding of the coefficient in the negative direction,
- floor truncation of small negative products,
- the priority of `clear_load` over `acc_en`.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_ADD  = 2'd2
    } mac_op_e;

endpackage

// File: rtl/fir_coef_quant.sv
module fir_coef_quant #(
    parameter int COEF_W  = 16,
    parameter int QCOEF_W = 12
) (
    input  logic [COEF_W-1:0]  coef_i,
    output logic [QCOEF_W-1:0] qcoef_o
);
    localparam int DROP = COEF_W - QCOEF_W;

    logic neg;
    logic lost;
    logic [QCOEF_W-1:0] nudge;

    always_comb begin
        neg   = coef_i[COEF_W-1];
        lost  = |coef_i[DROP-1:0];
        nudge = '0;
        nudge[0] = neg & lost;
        qcoef_o = coef_i[COEF_W-1:DROP] + nudge;
    end
endmodule

// File: rtl/fir_mul_stage.sv
module fir_mul_stage
    import fir_mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int QCOEF_W = 12,
    parameter int PROD_W  = DATA_W + QCOEF_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      clear_load,
    input  logic                      acc_en,
    input  logic signed [DATA_W-1:0]  data_i,
    input  logic signed [QCOEF_W-1:0] qcoef_i,
    output logic signed [PROD_W-1:0]  prod_o,
    output mac_op_e                   op_o,
    output logic                      valid_o
);
    logic signed [PROD_W-1:0] prod_d;
    mac_op_e op_d;

    assign prod_d = data_i * qcoef_i;

    always_comb begin
        op_d = OP_HOLD;
        if (in_valid) begin
            if (clear_load)  op_d = OP_LOAD;
            else if (acc_en) op_d = OP_ADD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_o  <= '0;
            op_o    <= OP_HOLD;
            valid_o <= 1'b0;
        end else begin
            prod_o  <= prod_d;
            op_o    <= op_d;
            valid_o <= in_valid;
        end
    end

    assert_stage_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> valid_o);
    assert_load_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clear_load) |=> (op_o == OP_LOAD));
endmodule

// File: rtl/fir_acc_stage.sv
module fir_acc_stage
    import fir_mac_pkg::*;
#(
    parameter int PROD_W = 28,
    parameter int PTRUNC = 4,
    parameter int ACC_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] prod_i,
    input  mac_op_e                  op_i,
    input  logic                     valid_i,
    output logic [ACC_W-1:0]         acc_o,
    output logic                     valid_o
);
    localparam int KEEP_W = PROD_W - PTRUNC;
    localparam int EXT_W  = ACC_W - KEEP_W;

    logic [ACC_W-1:0] aligned;
    logic [ACC_W-1:0] acc_d;

    assign aligned = {{EXT_W{prod_i[PROD_W-1]}}, prod_i[PROD_W-1:PTRUNC]};

    always_comb begin
        unique case (op_i)
            OP_LOAD: acc_d = aligned;
            OP_ADD:  acc_d = acc_o + aligned;
            default: acc_d = acc_o;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            acc_o   <= acc_d;
            valid_o <= valid_i;
        end
    end

    assert_load_replaces_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD) |=> (acc_o == $past(aligned)));
    assert_add_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD) |=> (acc_o == $past(acc_o) + $past(aligned)));
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_HOLD) |=> $stable(acc_o));
endmodule

// File: rtl/fir_mac.sv
module fir_mac
    import fir_mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COEF_W  = 16,
    parameter int QCOEF_W = 12,
    parameter int PTRUNC  = 4,
    parameter int ACC_W   = 32,
    parameter int TAP_LSB = 8,
    parameter int TAP_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              clear_load,
    input  logic              acc_en,
    input  logic [DATA_W-1:0] data_in,
    input  logic [COEF_W-1:0] coef_in,
    output logic [ACC_W-1:0]  acc_out,
    output logic [TAP_W-1:0]  cascade_out,
    output logic              out_valid
);
    localparam int PROD_W = DATA_W + QCOEF_W;
    localparam int DROP   = COEF_W - QCOEF_W;

    logic [QCOEF_W-1:0]       qcoef;
    logic signed [PROD_W-1:0] prod;
    mac_op_e                  op;
    logic                     s1_valid;

    fir_coef_quant #(.COEF_W(COEF_W), .QCOEF_W(QCOEF_W)) u_quant (
        .coef_i (coef_in),
        .qcoef_o(qcoef)
    );

    fir_mul_stage #(.DATA_W(DATA_W), .QCOEF_W(QCOEF_W), .PROD_W(PROD_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .clear_load(clear_load),
        .acc_en    (acc_en),
        .data_i    ($signed(data_in)),
        .qcoef_i   ($signed(qcoef)),
        .prod_o    (prod),
        .op_o      (op),
        .valid_o   (s1_valid)
    );

    fir_acc_stage #(.PROD_W(PROD_W), .PTRUNC(PTRUNC), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .prod_i (prod),
        .op_i   (op),
        .valid_i(s1_valid),
        .acc_o  (acc_out),
        .valid_o(out_valid)
    );

    assign cascade_out = acc_out[TAP_LSB+TAP_W-1:TAP_LSB];

    // Rounding toward zero: the error lies below one coefficient step and has the sign of the input
    int c_int;
    int q_int;
    assign c_int = int'($signed(coef_in));
    assign q_int = int'($signed(qcoef)) * (1 << DROP);

    assert_round_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((c_int >= 0) ? (q_int <= c_int && c_int - q_int < (1 << DROP))
                                   : (q_int >= c_int && q_int - c_int < (1 << DROP))));
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);
endmodule

// File: tb/test_fir_mac.sv
module test_fir_mac;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 10;

    // {valid, clear_load, acc_en, data, coef}
    localparam logic [34:0] VEC [NVEC] = '{
        {3'b110, 16'h1234, 16'h0A53},
        {3'b101, 16'hF000, 16'h8001},
        {3'b101, 16'h7FFF, 16'h7FFF},
        {3'b111, 16'h0100, 16'hFFF1},
        {3'b101, 16'h8001, 16'h000F},
        {3'b001, 16'h4000, 16'h4000},
        {3'b100, 16'h2222, 16'h3333},
        {3'b101, 16'hFFFF, 16'hFFFF},
        {3'b101, 16'h5A5A, 16'hC3C1},
        {3'b110, 16'h8000, 16'h7FF0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, clear_load = 1'b0, acc_en = 1'b0;
    logic [15:0] data_in = '0, coef_in = '0;
    logic [31:0] acc_out;
    logic [15:0] cascade_out;
    logic out_valid;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] model_acc = '0;
    logic [31:0] pend1_acc = '0, pend2_acc = '0;
    logic        pend1_v = 1'b0, pend2_v = 1'b0;
    string       pend1_tag = "R1", pend2_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    fir_mac i_fir_mac (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clear_load(clear_load),
        .acc_en(acc_en), .data_in(data_in), .coef_in(coef_in),
        .acc_out(acc_out), .cascade_out(cascade_out), .out_valid(out_valid)
    );

    function automatic logic [31:0] aligned_of(logic [15:0] d, logic [15:0] c);
        int qc;
        longint p;
        longint a;
        qc = int'($signed(c)) / 16;     // integer division truncates toward zero
        p  = longint'($signed(d)) * longint'(qc);
        a  = p >>> 4;                    // floor
        return a[31:0];
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_outputs();
        check(pend2_tag, acc_out, pend2_acc);
        check({pend2_tag, "/R8 valid"}, {31'd0, out_valid}, {31'd0, pend2_v});
        check("R10 cascade", {16'd0, cascade_out}, {16'd0, pend2_acc[23:8]});
    endtask

    // Called at a negedge: checks what is due now, then drives one input for one cycle
    task automatic step(string tag, logic v, logic cl, logic en, logic [15:0] d, logic [15:0] c);
        check_outputs();
        if (v && cl)      model_acc = aligned_of(d, c);
        else if (v && en) model_acc = model_acc + aligned_of(d, c);
        pend2_acc = pend1_acc; pend2_v = pend1_v; pend2_tag = pend1_tag;
        pend1_acc = model_acc; pend1_v = v;       pend1_tag = tag;
        in_valid = v; clear_load = cl; acc_en = en; data_in = d; coef_in = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic flush();
        step("R7 idle", 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
        step("R7 idle", 1'b0, 1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 acc", acc_out, 32'h0);
        check("R1 valid", {31'd0, out_valid}, 32'h0);
        check("R1 cascade", {16'd0, cascade_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R5 R6 R7 R8 mixed stream
        for (int i = 0; i < NVEC; i++) begin
            step("R5/R6/R7 table", VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
        end
        flush();

        // R2 rounding corners, fixed expectations
        step("R2 neg round", 1'b1, 1'b1, 1'b0, 16'h7FFF, 16'hFFFF);  // coef -> 0
        flush();
        check("R2 fixed", acc_out, 32'h0);
        step("R2 exact", 1'b1, 1'b1, 1'b0, 16'h0010, 16'hFFF0);      // coef -> -1, prod -16
        flush();
        check("R2 fixed", acc_out, 32'hFFFFFFFF);
        step("R2 neg step", 1'b1, 1'b1, 1'b0, 16'h0010, 16'h8001);   // coef -> -2047
        flush();
        check("R2 fixed", acc_out, 32'hFFFFF801);

        // R3 most negative pair
        step("R3 corner", 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000);
        flush();
        check("R3 fixed", acc_out, 32'h00400000);
        check("R3 R10 cascade", {16'd0, cascade_out}, 32'h00004000);

        // R4 floor truncation
        step("R4 neg", 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0010);
        flush();
        check("R4 fixed", acc_out, 32'hFFFFFFFF);
        step("R4 pos", 1'b1, 1'b1, 1'b0, 16'h0001, 16'h0010);
        flush();
        check("R4 fixed", acc_out, 32'h0);

        // R5 priority of load over add
        step("R5 seed", 1'b1, 1'b1, 1'b0, 16'h4000, 16'h4000);
        step("R5 prio", 1'b1, 1'b1, 1'b1, 16'h0001, 16'h0010);
        flush();
        check("R5 fixed", acc_out, 32'h0);

        // R9 wrap after 512 full-scale products
        step("R9 load", 1'b1, 1'b1, 1'b0, 16'h8000, 16'h8000);
        for (int k = 0; k < 511; k++) begin
            step("R9 add", 1'b1, 1'b0, 1'b1, 16'h8000, 16'h8000);
        end
        flush();
        check("R9 fixed", acc_out, 32'h80000000);
        check("R9 R10 cascade", {16'd0, cascade_out}, 32'h00000000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule